// File: doc/BRIEF.md
# Bus Clock Output Controller

This block derives the internal bus clock from the oscillator clock and decides whether that clock appears on an external pin. When running, the bus clock is high for one oscillator cycle and low for one, so its rate is half the oscillator rate. A stretch request that is present in the low cycle adds 0 to 3 extra oscillator cycles to the following high phase, so that a slow external device gets a longer access.

The operating mode is read from a two-bit select when reset ends and is then held. The mode sets the pin's default after reset. In normal single-chip mode the pin driver starts off. In special single-chip mode the pin driver starts on. In either mode a single software control bit can later turn the driver on or off. In special peripheral mode the pin is an input: the block resynchronises the external clock and uses it as the bus clock, and the driver stays off.

A stop request freezes the bus clock at its current level. When stop is released, the divider first spends one oscillator cycle low and then rises, so no short pulse is produced.

Top module: `bclk_out_ctrl`

## Requirements
- R1: When running without stretch, the bus clock is high for exactly one oscillator cycle and low for exactly one oscillator cycle.
- R2: In normal single-chip mode (mode code 00), pin_oe is 0 after reset. A write (cfg_wr=1) of cfg_en=1 sets pin_oe from the next oscillator cycle on, and pin_out equals bus_clk whenever pin_oe is 1.
- R3: In special single-chip mode (mode code 01), pin_oe is 1 after reset. A write of cfg_en=0 clears pin_oe from the next cycle on, and pin_out is 0 while pin_oe is 0.
- R4: In special peripheral mode (mode code 10), bus_clk follows ext_bclk with a delay of two oscillator cycles. pin_oe and pin_out stay 0 even after a write of cfg_en=1.
- R5: While stop_req is 1, bus_clk holds its level. This applies to the divided clock and to the peripheral-mode input clock.
- R6: In the first oscillator cycle after stop_req falls, the divided bus clock is low. In the next cycle it is high.
- R7: If stretch_req is 1 during a low cycle, the following high phase lasts 1+stretch_len oscillator cycles (stretch_len from 0 to 3).
- R8: The mode is sampled once, when reset ends. Later changes on mode_sel affect neither the pin default, the clock source, nor the divider.
- R9: Mode code 11 behaves exactly as normal single-chip mode: the pin driver is off after reset, the divided clock runs, and software can enable the pin.
- R10: While rst_n is low, bus_clk, pin_out and pin_oe are 0. They go to 0 at once when rst_n falls, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode code, sampled at reset release |
| stop_req | input | 1 | Freeze all clocks while high |
| cfg_wr | input | 1 | Write strobe for the pin enable bit |
| cfg_en | input | 1 | Value written to the pin enable bit |
| stretch_req | input | 1 | Stretch the next high phase |
| stretch_len | input | 2 | Extra high cycles for a stretch (0..3) |
| ext_bclk | input | 1 | External bus clock for peripheral mode |
| bus_clk | output | 1 | Internal bus clock |
| pin_out | output | 1 | Value driven on the clock pin |
| pin_oe | output | 1 | Output enable of the clock pin |

## Verification
Two situations are hard to reach from the ports. The first is the stop exit while the divider is frozen low. That is the only case where the forced low cycle can be told apart from ordinary toggling. The stimulus waits until bus_clk is sampled low before raising stop_req, then checks the two cycles after release one by one.

The second is the stretch request, which counts only in the single low cycle. A driver task aligns itself on that cycle before it presents each request and queues the expected high width. A monitor measures every high phase against that queue.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

  typedef enum logic [1:0] {
    MODE_NSC  = 2'b00,
    MODE_SSC  = 2'b01,
    MODE_SPER = 2'b10,
    MODE_RSVD = 2'b11
  } bclk_mode_e;

  // Reserved code is folded onto normal single-chip operation.
  function automatic bclk_mode_e mode_decode(input logic [1:0] code);
    bclk_mode_e m;
    m = bclk_mode_e'(code);
    if (m == MODE_RSVD) m = MODE_NSC;
    return m;
  endfunction

  function automatic logic mode_pin_default(input bclk_mode_e m);
    return (m == MODE_SSC);
  endfunction

endpackage

// File: rtl/bclk_sync.sv
module bclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign st_d[i] = en ? d : st_q[i];
    end else begin : g_rest
      assign st_d[i] = en ? st_q[i-1] : st_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else        st_q[i] <= st_d[i];
    end
  end

  assign q = st_q[STAGES-1];

endmodule

// File: rtl/bclk_divider.sv
module bclk_divider #(
  parameter int STRETCH_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 stop_req,
  input  logic                 stretch_req,
  input  logic [STRETCH_W-1:0] stretch_len,
  output logic                 ph_out
);

  logic                 ph_q, ph_d;
  logic [STRETCH_W-1:0] cnt_q, cnt_d;
  logic                 stop_q;
  logic                 stop_exit;

  assign stop_exit = stop_q & ~stop_req;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!run_en) begin
      ph_d  = 1'b0;
      cnt_d = '0;
    end else if (stop_req) begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
    end else if (stop_exit) begin
      ph_d  = 1'b0;
      cnt_d = '0;
    end else if (!ph_q) begin
      ph_d  = 1'b1;
      cnt_d = stretch_req ? stretch_len : '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      ph_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      stop_q <= stop_req;
    end
  end

  assign ph_out = ph_q;

  AST_LOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !stop_req && !stop_q && !ph_q) |=> ph_q); // R1

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> $stable(ph_q)); // R5

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !stop_req && !stop_q && ph_q && cnt_q != '0) |=> ph_q); // R7

endmodule

// File: rtl/bclk_pin_ctrl.sv
module bclk_pin_ctrl
  import bclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       cfg_wr,
  input  logic       cfg_en,
  output logic       armed,
  output bclk_mode_e mode,
  output logic       pin_en
);

  logic       armed_q;
  bclk_mode_e mode_q, mode_d;
  logic       en_q, en_d;

  always_comb begin
    mode_d = mode_q;
    en_d   = en_q;
    if (!armed_q) begin
      mode_d = mode_decode(mode_sel);
      en_d   = mode_pin_default(mode_decode(mode_sel));
    end else if (cfg_wr) begin
      en_d   = cfg_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode_q  <= MODE_NSC;
      en_q    <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      mode_q  <= mode_d;
      en_q    <= en_d;
    end
  end

  assign armed  = armed_q;
  assign mode   = mode_q;
  assign pin_en = en_q;

  AST_MODE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(mode_q)); // R8

  AST_EN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !cfg_wr) |=> $stable(en_q)); // R2

endmodule

// File: rtl/bclk_out_ctrl.sv
module bclk_out_ctrl
  import bclk_pkg::*;
#(
  parameter int STRETCH_W   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_osc,
  input  logic                 rst_n,
  input  logic [1:0]           mode_sel,
  input  logic                 stop_req,
  input  logic                 cfg_wr,
  input  logic                 cfg_en,
  input  logic                 stretch_req,
  input  logic [STRETCH_W-1:0] stretch_len,
  input  logic                 ext_bclk,
  output logic                 bus_clk,
  output logic                 pin_out,
  output logic                 pin_oe
);

  logic       rst_core_n;
  logic       armed;
  bclk_mode_e mode;
  logic       pin_en;
  logic       periph;
  logic       run_en;
  logic       div_ph;
  logic       ext_s;

  bclk_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .en    (1'b1),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  bclk_pin_ctrl u_pin (
    .clk      (clk_osc),
    .rst_n    (rst_core_n),
    .mode_sel (mode_sel),
    .cfg_wr   (cfg_wr),
    .cfg_en   (cfg_en),
    .armed    (armed),
    .mode     (mode),
    .pin_en   (pin_en)
  );

  assign periph = (mode == MODE_SPER);
  assign run_en = armed & ~periph;

  bclk_divider #(.STRETCH_W(STRETCH_W)) u_div (
    .clk         (clk_osc),
    .rst_n       (rst_core_n),
    .run_en      (run_en),
    .stop_req    (stop_req),
    .stretch_req (stretch_req),
    .stretch_len (stretch_len),
    .ph_out      (div_ph)
  );

  bclk_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk   (clk_osc),
    .rst_n (rst_core_n),
    .en    (~stop_req),
    .d     (ext_bclk),
    .q     (ext_s)
  );

  assign bus_clk = periph ? ext_s : div_ph;
  assign pin_oe  = pin_en & ~periph;
  assign pin_out = pin_oe & bus_clk;

endmodule

// File: tb/tb_bclk_out_ctrl.sv
`timescale 1ns/1ps
module tb_bclk_out_ctrl;

  logic       clk_osc = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       stop_req;
  logic       cfg_wr;
  logic       cfg_en;
  logic       stretch_req;
  logic [1:0] stretch_len;
  logic       ext_bclk;
  logic       bus_clk;
  logic       pin_out;
  logic       pin_oe;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  bit mon_on = 1'b0;

  always #2.5 clk_osc = ~clk_osc;

  bclk_out_ctrl dut (
    .clk_osc(clk_osc), .rst_n(rst_n), .mode_sel(mode_sel), .stop_req(stop_req),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .stretch_req(stretch_req),
    .stretch_len(stretch_len), .ext_bclk(ext_bclk), .bus_clk(bus_clk),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: measures high and low phases, compares high widths with the queue.
  int  hi_cnt = 0;
  int  lo_cnt = 0;
  bit  seen_fall = 1'b0;
  always @(negedge clk_osc) begin
    if (!mon_on) begin
      hi_cnt = 0; lo_cnt = 0; seen_fall = 1'b0;
    end else begin
      if (pin_oe) chk("R2", "pin_out follows bus_clk", pin_out, bus_clk);
      if (bus_clk) begin
        if (seen_fall && hi_cnt == 0) chk("R1", "low phase width", lo_cnt, 1);
        hi_cnt++;
      end else begin
        if (hi_cnt > 0) begin
          seen_fall = 1'b1;
          if (exp_q.size() > 0) chk("R7", "high phase width", hi_cnt, exp_q.pop_front());
          hi_cnt = 0; lo_cnt = 0;
        end
        lo_cnt++;
      end
    end
  end

  // Driver: aligns on a low cycle, presents a stretch, queues the expected width.
  task automatic run_pulses(input int n, input bit sreq, input int len);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_osc);
      while (bus_clk) @(negedge clk_osc);
      stretch_req = sreq;
      stretch_len = len[1:0];
      #1;
      exp_q.push_back(sreq ? 1 + len : 1);
      @(negedge clk_osc);
    end
    stretch_req = 1'b0;
    stretch_len = 2'd0;
  endtask

  task automatic drain();
    repeat (10) @(negedge clk_osc);
    chk("R7", "all queued pulses observed", exp_q.size(), 0);
  endtask

  task automatic do_reset(input logic [1:0] m);
    mon_on = 1'b0;
    @(negedge clk_osc);
    rst_n = 1'b0; mode_sel = m; stop_req = 1'b0; cfg_wr = 1'b0;
    stretch_req = 1'b0; ext_bclk = 1'b0;
    repeat (3) @(negedge clk_osc);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_osc);
  endtask

  task automatic sw_write(input logic v);
    @(negedge clk_osc);
    cfg_wr = 1'b1; cfg_en = v;
    @(negedge clk_osc);
    cfg_wr = 1'b0;
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b01; stop_req = 1'b0; cfg_wr = 1'b0; cfg_en = 1'b0;
    stretch_req = 1'b0; stretch_len = 2'd0; ext_bclk = 1'b0;
    repeat (3) @(negedge clk_osc);
    chk("R10", "bus_clk in reset", bus_clk, 0);
    chk("R10", "pin_oe in reset", pin_oe, 0);
    chk("R10", "pin_out in reset", pin_out, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_osc);

    // Special single-chip
    chk("R3", "pin_oe default on", pin_oe, 1);
    mon_on = 1'b1;
    run_pulses(4, 1'b0, 0);
    drain();
    mon_on = 1'b0;
    sw_write(1'b0);
    chk("R3", "pin_oe after clear", pin_oe, 0);
    repeat (2) @(negedge clk_osc);
    chk("R3", "pin_out quiet", pin_out, 0);
    sw_write(1'b1);
    chk("R3", "pin_oe after set", pin_oe, 1);
    #1 rst_n = 1'b0;
    #1;
    chk("R10", "async pin_oe", pin_oe, 0);
    chk("R10", "async bus_clk", bus_clk, 0);

    // Normal single-chip
    do_reset(2'b00);
    chk("R2", "pin_oe default off", pin_oe, 0);
    mode_sel = 2'b10; ext_bclk = 1'b1;
    repeat (4) @(negedge clk_osc);
    chk("R8", "pin_oe after mode_sel change", pin_oe, 0);
    mon_on = 1'b1;
    run_pulses(1, 1'b1, 1);
    run_pulses(1, 1'b1, 3);
    run_pulses(1, 1'b1, 2);
    run_pulses(1, 1'b0, 3);
    run_pulses(1, 1'b1, 0);
    run_pulses(2, 1'b0, 0);
    drain();
    mon_on = 1'b0;
    sw_write(1'b1);
    chk("R2", "pin_oe after set", pin_oe, 1);
    mon_on = 1'b1;
    run_pulses(3, 1'b0, 0);
    drain();
    mon_on = 1'b0;

    // Stop while low
    @(negedge clk_osc);
    while (bus_clk) @(negedge clk_osc);
    stop_req = 1'b1;
    repeat (5) @(negedge clk_osc);
    chk("R5", "frozen low", bus_clk, 0);
    stop_req = 1'b0;
    @(negedge clk_osc);
    chk("R6", "first cycle after stop low", bus_clk, 0);
    @(negedge clk_osc);
    chk("R6", "second cycle after stop high", bus_clk, 1);
    // Stop while high
    @(negedge clk_osc);
    while (!bus_clk) @(negedge clk_osc);
    stop_req = 1'b1;
    repeat (5) @(negedge clk_osc);
    chk("R5", "frozen high", bus_clk, 1);
    chk("R5", "pin_out frozen high", pin_out, 1);
    stop_req = 1'b0;
    @(negedge clk_osc);
    chk("R6", "low after stop exit", bus_clk, 0);
    @(negedge clk_osc);
    chk("R6", "rise after stop exit", bus_clk, 1);

    // Special peripheral
    do_reset(2'b10);
    chk("R4", "pin_oe off", pin_oe, 0);
    ext_bclk = 1'b1;
    @(negedge clk_osc);
    chk("R4", "ext sync delay 1", bus_clk, 0);
    @(negedge clk_osc);
    chk("R4", "ext sync delay 2", bus_clk, 1);
    sw_write(1'b1);
    chk("R4", "write ignored on pin_oe", pin_oe, 0);
    chk("R4", "pin_out stays low", pin_out, 0);
    stop_req = 1'b1; ext_bclk = 1'b0;
    repeat (4) @(negedge clk_osc);
    chk("R5", "ext clock frozen", bus_clk, 1);
    stop_req = 1'b0;
    repeat (3) @(negedge clk_osc);
    chk("R4", "ext clock resumes", bus_clk, 0);

    // Reserved code
    do_reset(2'b11);
    chk("R9", "pin_oe off", pin_oe, 0);
    ext_bclk = 1'b1;
    mon_on = 1'b1;
    run_pulses(3, 1'b0, 0);
    run_pulses(1, 1'b1, 2);
    drain();
    mon_on = 1'b0;
    sw_write(1'b1);
    chk("R9", "pin_oe enabled by software", pin_oe, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule